// File: doc/BRIEF.md
# Half-Cycle Mean-Square and Average Power Accumulator

This block takes paired voltage and current codes from two converter channels that sample together at a few mega-samples per second. Over one half-cycle of the mains it builds three running sums: the squared voltage code, the squared current code, and their product. It also counts the samples. Before either current term is formed, a fixed mid-scale bias is subtracted from the current code. An external half-cycle marker closes the window. The sums and the count are captured and the accumulators restart in that same cycle, so no sample is lost.

Three serial dividers then run in lockstep and divide the captured sums by the sample count. They yield the mean-square voltage, the mean-square current and the mean power, and these are presented with a one-cycle strobe. Taking the square root and scaling to volts, amperes or watts is left to whatever reads the results.

Top module: `hcp_meter`

## Requirements
- R1: After reset, `ms_v`, `ms_i`, `pwr_avg` and `win_count` are zero and `result_valid` is low.
- R2: The current term uses the signed value `i_code - I_BIAS`, where `I_BIAS` defaults to 2048 (mid-scale of a 12-bit code). The voltage code is used unsigned.
- R3: `ms_v` equals the sum of `v_code*v_code` over the window's samples, divided by the sample count and rounded down.
- R4: `ms_i` equals the sum of `(i_code-I_BIAS)^2` over the window, divided by the sample count and rounded down.
- R5: `pwr_avg` is a two's-complement value. It equals the sum of `v_code*(i_code-I_BIAS)` over the window divided by the count, truncated toward zero.
- R6: `win_count` reports how many cycles of the window had `smp_valid` high. Cycles with `smp_valid` low contribute nothing, whatever the input codes.
- R7: A sample presented in the same cycle as `half_mark` is counted in the window that the marker opens, not in the window it closes.
- R8: `result_valid` is a one-cycle pulse that appears ACC_W+1 rising edges after the edge that sampled an accepted marker. All result outputs hold their values between pulses.
- R9: A window that closes with zero samples produces a pulse with all four result outputs at zero.
- R10: A marker that arrives fewer than ACC_W+1 edges after the previously accepted marker still restarts accumulation. The window it closes yields no result, and the result already in progress is delivered unchanged.
- R11: A window of 40,000 full-scale samples produces exact means with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| v_code | input | SMP_W | Unsigned voltage code |
| i_code | input | SMP_W | Current code carrying a mid-scale bias |
| half_mark | input | 1 | One-cycle pulse that closes the current window |
| ms_v | output | 2*SMP_W | Mean-square voltage code |
| ms_i | output | 2*SMP_W | Mean-square unbiased current code |
| pwr_avg | output | 2*SMP_W+1 | Signed mean product |
| win_count | output | CNT_W | Sample count of the reported window |
| result_valid | output | 1 | One-cycle strobe marking new results |

## Verification
The assertions check several properties on every clock. The accumulators never wrap and the count always has headroom. A marker leaves the count at one or zero, depending on whether a sample arrived with it. The divider remainder stays below the divisor. The three dividers stay in lockstep, each quotient fits its output width, and the result strobe lasts one cycle with the outputs stable between strobes. Only the bench scenarios can show that the arithmetic is right for a whole window. That covers bias removal at the code extremes, truncation of negative means toward zero, the destination of the sample that coincides with a marker, discarded early markers, and a long full-scale window.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } dv_phase_e;

endpackage

// File: rtl/hcp_sample_prep.sv
module hcp_sample_prep #(
    parameter int SMP_W  = 12,
    parameter int I_BIAS = 2048
) (
    input  logic [SMP_W-1:0]          v_code,
    input  logic [SMP_W-1:0]          i_code,
    output logic [2*SMP_W-1:0]        v_sq,
    output logic [2*SMP_W-1:0]        i_sq,
    output logic signed [2*SMP_W:0]   vi_prod
);
    localparam int SQ_W = 2 * SMP_W;
    localparam int PR_W = SQ_W + 1;

    logic signed [SMP_W:0] i_ctr;
    logic [SQ_W-1:0]        v_ext_sq;
    logic signed [SQ_W-1:0] i_ext_sq;
    logic signed [PR_W-1:0] v_ext_pr;
    logic signed [PR_W-1:0] i_ext_pr;

    // Remove the mid-scale bias from the current channel (R2)
    assign i_ctr    = $signed({1'b0, i_code}) - $signed((SMP_W+1)'(I_BIAS));

    assign v_ext_sq = {{SMP_W{1'b0}}, v_code};
    assign i_ext_sq = {{(SQ_W-SMP_W-1){i_ctr[SMP_W]}}, i_ctr};
    assign v_ext_pr = $signed({{(PR_W-SMP_W){1'b0}}, v_code});
    assign i_ext_pr = {{(PR_W-SMP_W-1){i_ctr[SMP_W]}}, i_ctr};

    assign v_sq    = v_ext_sq * v_ext_sq;
    assign i_sq    = i_ext_sq * i_ext_sq;
    assign vi_prod = v_ext_pr * i_ext_pr;

endmodule

// File: rtl/hcp_accum.sv
module hcp_accum #(
    parameter int SMP_W = 12,
    parameter int CNT_W = 16,
    parameter int ACC_W = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_valid,
    input  logic                      half_mark,
    input  logic [2*SMP_W-1:0]        v_sq,
    input  logic [2*SMP_W-1:0]        i_sq,
    input  logic signed [2*SMP_W:0]   vi_prod,
    output logic [ACC_W-1:0]          acc_v,
    output logic [ACC_W-1:0]          acc_i,
    output logic [ACC_W-1:0]          acc_p,
    output logic [CNT_W-1:0]          acc_n
);
    localparam int SQ_W = 2 * SMP_W;
    localparam int PR_W = SQ_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] sv;
        logic [ACC_W-1:0] si;
        logic [ACC_W-1:0] sp;
        logic [CNT_W-1:0] n;
    } acc_t;

    acc_t st_d, st_q;
    acc_t base;

    logic [ACC_W-1:0] add_v, add_i, add_p;

    assign add_v = {{(ACC_W-SQ_W){1'b0}}, v_sq};
    assign add_i = {{(ACC_W-SQ_W){1'b0}}, i_sq};
    assign add_p = {{(ACC_W-PR_W){vi_prod[PR_W-1]}}, vi_prod};

    always_comb begin
        // A marker restarts the window; a coincident sample opens the new one (R7)
        base = half_mark ? '0 : st_q;
        st_d = base;
        if (smp_valid) begin
            st_d.sv = base.sv + add_v;
            st_d.si = base.si + add_i;
            st_d.sp = base.sp + add_p;
            st_d.n  = base.n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_v = st_q.sv;
    assign acc_i = st_q.si;
    assign acc_p = st_q.sp;
    assign acc_n = st_q.n;

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !half_mark) |=> (st_q.sv >= $past(st_q.sv)) && (st_q.si >= $past(st_q.si)));

    p_count_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !half_mark) |-> (st_q.n != {CNT_W{1'b1}}));

    p_mark_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_mark |=> (st_q.n == {{(CNT_W-1){1'b0}}, $past(smp_valid)}));

endmodule

// File: rtl/hcp_divider.sv
module hcp_divider import hcp_pkg::*; #(
    parameter int NUM_W      = 48,
    parameter int DEN_W      = 16,
    parameter bit SIGNED_NUM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_W-1:0]  num,
    input  logic [DEN_W-1:0]  den,
    output logic              busy,
    output logic              done,
    output logic [NUM_W-1:0]  quot
);
    localparam int STEP_W = $clog2(NUM_W);

    typedef struct packed {
        dv_phase_e         ph;
        logic [NUM_W-1:0]  acc;
        logic [DEN_W:0]    rem;
        logic [DEN_W-1:0]  dv;
        logic [STEP_W-1:0] step;
        logic              neg;
    } div_t;

    div_t st_d, st_q;

    logic             num_neg;
    logic [NUM_W-1:0] num_mag;
    logic [DEN_W:0]   trial;
    logic             fits;

    generate
        if (SIGNED_NUM) begin : g_signed
            assign num_neg = num[NUM_W-1];
        end else begin : g_unsigned
            assign num_neg = 1'b0;
        end
    endgenerate

    assign num_mag = num_neg ? (~num + 1'b1) : num;
    assign trial   = {st_q.rem[DEN_W-1:0], st_q.acc[NUM_W-1]};
    assign fits    = (trial >= {1'b0, st_q.dv});

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            DV_RUN: begin
                st_d.rem = fits ? (trial - {1'b0, st_q.dv}) : trial;
                st_d.acc = {st_q.acc[NUM_W-2:0], fits};
                if (st_q.step == '0) st_d.ph = DV_DONE;
                else                 st_d.step = st_q.step - 1'b1;
            end
            default: begin
                st_d.ph = DV_IDLE;
                if (start) begin
                    st_d.ph   = DV_RUN;
                    st_d.acc  = num_mag;
                    st_d.rem  = '0;
                    st_d.dv   = den;
                    st_d.step = STEP_W'(NUM_W - 1);
                    st_d.neg  = num_neg;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.ph == DV_RUN);
    assign done = (st_q.ph == DV_DONE);
    assign quot = st_q.neg ? (~st_q.acc + 1'b1) : st_q.acc;

    p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == DV_RUN && st_q.dv != '0) |-> (st_q.rem < {1'b0, st_q.dv}));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/hcp_meter.sv
module hcp_meter #(
    parameter int SMP_W  = 12,
    parameter int CNT_W  = 16,
    parameter int ACC_W  = 48,
    parameter int I_BIAS = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [SMP_W-1:0]         v_code,
    input  logic [SMP_W-1:0]         i_code,
    input  logic                     half_mark,
    output logic [2*SMP_W-1:0]       ms_v,
    output logic [2*SMP_W-1:0]       ms_i,
    output logic signed [2*SMP_W:0]  pwr_avg,
    output logic [CNT_W-1:0]         win_count,
    output logic                     result_valid
);
    localparam int OUT_W = 2 * SMP_W;
    localparam int PR_W  = OUT_W + 1;
    localparam int N_CH  = 3;

    logic [OUT_W-1:0]        v_sq, i_sq;
    logic signed [PR_W-1:0]  vi_prod;
    logic [ACC_W-1:0]        acc_v, acc_i, acc_p;
    logic [CNT_W-1:0]        acc_n;
    logic                    start;

    logic [ACC_W-1:0] div_num  [N_CH];
    logic [ACC_W-1:0] div_quot [N_CH];
    logic [N_CH-1:0]  div_busy;
    logic [N_CH-1:0]  div_done;

    typedef struct packed {
        logic [OUT_W-1:0] ms_v;
        logic [OUT_W-1:0] ms_i;
        logic [PR_W-1:0]  pwr;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             empty;
        logic [CNT_W-1:0] cnt_hold;
    } out_t;

    out_t st_d, st_q;

    hcp_sample_prep #(.SMP_W(SMP_W), .I_BIAS(I_BIAS)) prep_i (
        .v_code  (v_code),
        .i_code  (i_code),
        .v_sq    (v_sq),
        .i_sq    (i_sq),
        .vi_prod (vi_prod)
    );

    hcp_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .half_mark (half_mark),
        .v_sq      (v_sq),
        .i_sq      (i_sq),
        .vi_prod   (vi_prod),
        .acc_v     (acc_v),
        .acc_i     (acc_i),
        .acc_p     (acc_p),
        .acc_n     (acc_n)
    );

    // A marker while the dividers run restarts accumulation only (R10)
    assign start = half_mark & ~div_busy[0];

    assign div_num[0] = acc_v;
    assign div_num[1] = acc_i;
    assign div_num[2] = acc_p;

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_div
            hcp_divider #(
                .NUM_W      (ACC_W),
                .DEN_W      (CNT_W),
                .SIGNED_NUM (g == 2)
            ) div_i (
                .clk   (clk),
                .rst_n (rst_n),
                .start (start),
                .num   (div_num[g]),
                .den   (acc_n),
                .busy  (div_busy[g]),
                .done  (div_done[g]),
                .quot  (div_quot[g])
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (div_done[0]) begin
            st_d.valid = 1'b1;
            st_d.cnt   = st_q.cnt_hold;
            st_d.ms_v  = st_q.empty ? '0 : div_quot[0][OUT_W-1:0];
            st_d.ms_i  = st_q.empty ? '0 : div_quot[1][OUT_W-1:0];
            st_d.pwr   = st_q.empty ? '0 : div_quot[2][PR_W-1:0];
        end
        if (start) begin
            st_d.empty    = (acc_n == '0);
            st_d.cnt_hold = acc_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ms_v         = st_q.ms_v;
    assign ms_i         = st_q.ms_i;
    assign pwr_avg      = $signed(st_q.pwr);
    assign win_count    = st_q.cnt;
    assign result_valid = st_q.valid;

    p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(ms_v) && $stable(ms_i) && $stable(pwr_avg) && $stable(win_count)));

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && win_count == '0) |-> (ms_v == '0 && ms_i == '0 && pwr_avg == '0));

    p_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done[1] == div_done[0]) && (div_done[2] == div_done[0]) &&
        (div_busy[1] == div_busy[0]) && (div_busy[2] == div_busy[0]));

    p_mean_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done[0] && !st_q.empty) |->
            (div_quot[0][ACC_W-1:OUT_W] == '0) && (div_quot[1][ACC_W-1:OUT_W] == '0));

    p_power_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done[2] && !st_q.empty) |->
            (div_quot[2][ACC_W-1:PR_W-1] == '0) || (div_quot[2][ACC_W-1:PR_W-1] == '1));

endmodule

// File: tb/hcp_meter_tb.sv
module hcp_meter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SMP_W      = 12;
    localparam int CNT_W      = 16;
    localparam int ACC_W      = 48;
    localparam int I_BIAS     = 2048;
    localparam int LAT        = ACC_W + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic smp_valid;
    logic half_mark;
    logic [SMP_W-1:0] v_code, i_code;
    logic [2*SMP_W-1:0] ms_v, ms_i;
    logic signed [2*SMP_W:0] pwr_avg;
    logic [CNT_W-1:0] win_count;
    logic result_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcp_meter #(.SMP_W(SMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .I_BIAS(I_BIAS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .v_code       (v_code),
        .i_code       (i_code),
        .half_mark    (half_mark),
        .ms_v         (ms_v),
        .ms_i         (ms_i),
        .pwr_avg      (pwr_avg),
        .win_count    (win_count),
        .result_valid (result_valid)
    );

    int n_chk = 0;
    int n_err = 0;

    longint m_sv = 0, m_si = 0, m_sp = 0, m_n = 0;
    longint p_sv = 0, p_si = 0, p_sp = 0, p_n = 0;
    bit     p_vld = 1'b0;
    string  p_tag = "";
    string  cur_tag = "";
    int     since_acc = 100000;

    task automatic chk(input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got %0d exp %0d", what, got, exp);
        end
    endtask

    // One clock of stimulus plus the reference model of the window
    task automatic drive(input logic vld, input int v, input int i, input logic mk);
        @(negedge clk);
        smp_valid = vld;
        v_code    = v[SMP_W-1:0];
        i_code    = i[SMP_W-1:0];
        half_mark = mk;
        @(posedge clk);
        since_acc++;
        if (mk) begin
            if (since_acc >= LAT) begin
                p_sv = m_sv; p_si = m_si; p_sp = m_sp; p_n = m_n;
                p_tag = cur_tag;
                p_vld = 1'b1;
                since_acc = 0;
            end
            m_sv = 0; m_si = 0; m_sp = 0; m_n = 0;
        end
        if (vld) begin
            m_sv += longint'(v) * longint'(v);
            m_si += longint'(i - I_BIAS) * longint'(i - I_BIAS);
            m_sp += longint'(v) * longint'(i - I_BIAS);
            m_n++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 0, 0, 1'b0);
    endtask

    task automatic wait_result();
        for (int k = 0; k < LAT + 10 && p_vld; k++) drive(1'b0, 0, 0, 1'b0);
        if (p_vld) begin
            n_chk++; n_err++;
            $display("FAIL R8 %s no result strobe got 0 exp 1", p_tag);
            p_vld = 1'b0;
        end
    endtask

    task automatic close_window(input string tag);
        cur_tag = tag;
        drive(1'b0, 0, 0, 1'b1);
        wait_result();
    endtask

    // Result monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && result_valid === 1'b1) begin
            if (!p_vld) begin
                n_chk++; n_err++;
                $display("FAIL R10 unexpected result strobe got 1 exp 0");
            end else begin
                chk({p_tag, " R3 ms_v"}, longint'(ms_v), (p_n == 0) ? 0 : p_sv / p_n);
                chk({p_tag, " R4 ms_i"}, longint'(ms_i), (p_n == 0) ? 0 : p_si / p_n);
                chk({p_tag, " R5 pwr_avg"}, longint'(pwr_avg), (p_n == 0) ? 0 : p_sp / p_n);
                chk({p_tag, " R6 win_count"}, longint'(win_count), p_n);
                chk({p_tag, " R8 latency"}, longint'(since_acc), longint'(LAT));
                p_vld = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired got running exp finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int vs[4];
        int is[6];
        vs = '{0, 1, 2047, 4095};
        is = '{0, 1, 2047, 2048, 2049, 4095};
        rst_n = 1'b0; smp_valid = 1'b0; half_mark = 1'b0; v_code = '0; i_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 result_valid", longint'(result_valid), 0);
        chk("R1 ms_v", longint'(ms_v), 0);
        chk("R1 ms_i", longint'(ms_i), 0);
        chk("R1 pwr_avg", longint'(pwr_avg), 0);
        chk("R1 win_count", longint'(win_count), 0);

        // R3 R4 R5 R6: swept codes with gaps in smp_valid
        for (int k = 0; k < 300; k++)
            drive((k % 5) != 3, (k * 37) % 4096, (k * 91 + 5) % 4096, 1'b0);
        close_window("sweep");

        // R2: single-sample windows at the code extremes around the bias
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 6; b++) begin
                drive(1'b1, vs[a], is[b], 1'b0);
                close_window("R2 corner");
            end
        end

        // R5: negative sum -7 over 2 samples must give -3, not -4
        drive(1'b1, 1, 2043, 1'b0);
        drive(1'b1, 1, 2046, 1'b0);
        close_window("R5 trunc");

        // R9: empty window
        close_window("R9 empty");

        // R6: invalid cycles carry wild codes that must be ignored
        drive(1'b0, 4095, 0, 1'b0);
        drive(1'b0, 4095, 4095, 1'b0);
        drive(1'b1, 100, 2100, 1'b0);
        drive(1'b0, 3000, 17, 1'b0);
        drive(1'b1, 200, 1900, 1'b0);
        close_window("R6 gaps");

        // R7: sample coinciding with the marker opens the next window
        drive(1'b1, 10, 2060, 1'b0);
        drive(1'b1, 20, 2070, 1'b0);
        drive(1'b1, 30, 2080, 1'b0);
        cur_tag = "R7 first";
        drive(1'b1, 500, 3000, 1'b1);
        wait_result();
        drive(1'b1, 40, 1000, 1'b0);
        drive(1'b1, 50, 1100, 1'b0);
        close_window("R7 carry");

        // R10: early marker discards its window, in-flight result intact
        for (int k = 0; k < 10; k++) drive(1'b1, 300 + k, 2500 - k * 7, 1'b0);
        cur_tag = "R10 kept";
        drive(1'b0, 0, 0, 1'b1);
        for (int k = 0; k < 5; k++) drive(1'b1, 4000, 10, 1'b0);
        drive(1'b0, 0, 0, 1'b1);
        for (int k = 0; k < 7; k++) drive(1'b1, 600 + k, 2200 + k, 1'b0);
        wait_result();
        close_window("R10 after");

        // R11: long full-scale window
        for (int k = 0; k < 40000; k++) drive(1'b1, 4095, 0, 1'b0);
        close_window("R11 full");

        idle(5);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule